// File: doc/BRIEF.md
# SDRAM Mode Programming Decoder

This block sits between a CPU bus and an SDRAM command port. It lets software program the SDRAM mode register with an ordinary store. The store goes to a reserved address window, and the mode value rides on the address lines: to load value V, the CPU writes to window base plus V, scaled for the SDRAM bus width. Whatever is on the data bus during that store is discarded. On such a store the block issues one mode-register-set command to the SDRAM. That command reaches the chip selects of both SDRAM areas at once, and the CPU is acknowledged only after it has gone out.

Until the first mode set has happened, the block refuses every ordinary SDRAM access. The CPU gets an error response, and nothing is passed to the downstream memory controller. Once a mode set has been issued, ordinary accesses outside the window pass straight through to the downstream controller, and that controller's acknowledge is returned to the CPU. The mode register cannot be read back: a read inside the window is acknowledged but carries no meaningful data.

The CPU holds `cpuReq` and its qualifiers steady until it sees `cpuAck` or `cpuErr`, and it drops them in the cycle after that.

Top module: `sdram_modeset_gate`

## Requirements
- R1: After reset the SDRAM command pins are idle: every chip select, RAS, CAS and WE are high (1), and `sdAddr` is 0. `cpuAck`, `cpuErr` and `fwdReq` are all low.
- R2: With `busIs16`=0 (32-bit SDRAM bus), a write inside the window drives `sdAddr` with the window offset shifted right by two, which is offset bits [MODE_W+1:2].
- R3: With `busIs16`=1 (16-bit SDRAM bus), the value is offset bits [MODE_W:1]. Offset bit MODE_W+1 is dropped, so the upper half of the window aliases onto the lower half.
- R4: A write inside the window sampled at clock edge N produces the mode-register-set command from edge N to edge N+1, and for exactly that one cycle. The command drives all chip selects low together with RAS, CAS and WE low.
- R5: The data bus has no effect on a window write: two writes to the same window address with different data produce the same `sdAddr` value.
- R6: `cpuAck` for a window write is high for exactly one cycle, the cycle right after the command cycle.
- R7: Before any mode set, a request outside the window gets `cpuErr` high for one cycle, starting the cycle after it is sampled. In that case `fwdReq` stays low. Addresses both below and above the window count as outside.
- R8: After a mode set, a request outside the window drives `fwdReq` high in the same cycle, with `fwdWr`, `fwdAddr` and `fwdWdata` equal to the CPU's values. In that state `cpuAck` follows `fwdAck`.
- R9: A read inside the window is acknowledged in the cycle after it is sampled. It issues no command and does not lift the block on ordinary accesses.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock for the SDRAM side and the CPU side |
| rstN | input | 1 | Active-low synchronous reset |
| busIs16 | input | 1 | SDRAM bus width select: 1 means 16-bit, 0 means 32-bit |
| cpuReq | input | 1 | CPU request, held until it is acknowledged or refused |
| cpuWr | input | 1 | 1 for a write, 0 for a read |
| cpuAddr | input | ADDR_W | CPU byte address |
| cpuWdata | input | DATA_W | CPU write data, passed on only for ordinary accesses |
| cpuAck | output | 1 | Completion of a window access, or the downstream acknowledge |
| cpuErr | output | 1 | Ordinary access refused because the mode is not yet set |
| fwdReq | output | 1 | Ordinary request passed to the downstream controller |
| fwdWr | output | 1 | Write flag of the passed-on request |
| fwdAddr | output | ADDR_W | Address of the passed-on request |
| fwdWdata | output | DATA_W | Write data of the passed-on request |
| fwdAck | input | 1 | Acknowledge from the downstream controller |
| sdCsN | output | NUM_AREAS | Active-low chip selects, one per SDRAM area |
| sdRasN | output | 1 | Active-low row strobe |
| sdCasN | output | 1 | Active-low column strobe |
| sdWeN | output | 1 | Active-low write enable |
| sdAddr | output | MODE_W | SDRAM address pins, which carry the mode value |

## Verification
Suppose the value capture is wrong, for example the shift picks the wrong slice or ignores the width select. The fault then shows on `sdAddr` in the very cycle the command is on the pins, one edge after the store is sampled. A full sweep of every window offset at both bus widths exposes any slice or aliasing error. A wrong lock state shows on the next ordinary request: either `fwdReq` rises combinationally when it should not, or `cpuErr` appears one edge later when it should not. Sequencing faults in the controller move the acknowledge or stretch the command beyond one cycle, and the cycle-exact sampling of the bench catches either at once.

// File: rtl/modeset_pkg.sv
package modeset_pkg;

  typedef enum logic [1:0] {
    ST_IDLE = 2'd0,
    ST_MRS  = 2'd1,
    ST_ACK  = 2'd2,
    ST_ERR  = 2'd3
  } ctlState_t;

  // strobes from control to datapath
  typedef struct packed {
    logic loadMrs;
  } ctlStrobe_t;

  // active-low command triple on the SDRAM pins
  typedef struct packed {
    logic rasN;
    logic casN;
    logic weN;
  } sdCmd_t;

  localparam sdCmd_t CMD_NOP = 3'b111;
  localparam sdCmd_t CMD_MRS = 3'b000;

endpackage

// File: rtl/modeset_ctrl.sv
module modeset_ctrl
  import modeset_pkg::*;
(
  input  logic       clk,
  input  logic       rstN,
  input  logic       cpuReq,
  input  logic       cpuWr,
  input  logic       inWin,
  output ctlStrobe_t strobe,
  output logic       ackWin,
  output logic       errOut,
  output logic       fwdEn
);

  ctlState_t st, stNxt;
  logic      modeDone;

  always_comb begin
    stNxt  = st;
    strobe = '0;
    case (st)
      ST_IDLE: begin
        if (cpuReq) begin
          if (inWin) begin
            if (cpuWr) begin
              stNxt          = ST_MRS;
              strobe.loadMrs = 1'b1;
            end else begin
              stNxt = ST_ACK;
            end
          end else if (!modeDone) begin
            stNxt = ST_ERR;
          end
        end
      end
      ST_MRS:  stNxt = ST_ACK;
      ST_ACK:  stNxt = ST_IDLE;
      ST_ERR:  stNxt = ST_IDLE;
      default: stNxt = ST_IDLE;
    endcase
  end

  always_ff @(posedge clk) begin
    if (!rstN) begin
      st       <= ST_IDLE;
      modeDone <= 1'b0;
    end else begin
      st <= stNxt;
      if (strobe.loadMrs) modeDone <= 1'b1;
    end
  end

  assign ackWin = (st == ST_ACK);
  assign errOut = (st == ST_ERR);
  assign fwdEn  = (st == ST_IDLE) && cpuReq && !inWin && modeDone;

  AST_ACK_TWO_AFTER_LOAD: assert property (@(posedge clk) disable iff (!rstN)
    strobe.loadMrs |=> ##1 ackWin); // R6
  AST_ERR_SINGLE: assert property (@(posedge clk) disable iff (!rstN)
    errOut |=> !errOut); // R7
  AST_ACK_SINGLE: assert property (@(posedge clk) disable iff (!rstN)
    ackWin |=> !ackWin); // R6

endmodule

// File: rtl/modeset_dp.sv
module modeset_dp
  import modeset_pkg::*;
#(
  parameter int                ADDR_W    = 32,
  parameter int                MODE_W    = 16,
  parameter int                NUM_AREAS = 2,
  parameter logic [ADDR_W-1:0] WIN_BASE  = '0
) (
  input  logic                 clk,
  input  logic                 rstN,
  input  logic [ADDR_W-1:0]    cpuAddr,
  input  logic                 busIs16,
  input  ctlStrobe_t           strobe,
  output logic                 inWin,
  output logic [NUM_AREAS-1:0] sdCsN,
  output logic                 sdRasN,
  output logic                 sdCasN,
  output logic                 sdWeN,
  output logic [MODE_W-1:0]    sdAddr
);

  localparam int WIN_LOG2 = MODE_W + 2;
  localparam int TAG_W    = ADDR_W - WIN_LOG2;
  localparam logic [TAG_W-1:0] WIN_TAG = WIN_BASE[ADDR_W-1:WIN_LOG2];

  // window decode (base is aligned to the window size)
  assign inWin = (cpuAddr[ADDR_W-1:WIN_LOG2] == WIN_TAG);

  // value carried on the address lines, scaled for bus width
  logic [MODE_W-1:0] valWide, valNarrow, modeVal;
  assign valWide   = cpuAddr[MODE_W+1:2];
  assign valNarrow = cpuAddr[MODE_W:1];
  assign modeVal   = busIs16 ? valNarrow : valWide;

  sdCmd_t            cmdQ;
  logic [MODE_W-1:0] addrQ;

  always_ff @(posedge clk) begin
    if (!rstN) begin
      cmdQ  <= CMD_NOP;
      addrQ <= '0;
    end else if (strobe.loadMrs) begin
      cmdQ  <= CMD_MRS;
      addrQ <= modeVal;
    end else begin
      cmdQ  <= CMD_NOP;
      addrQ <= '0;
    end
  end

  // one chip select flop per area; all areas take the same command
  genvar g;
  generate
    for (g = 0; g < NUM_AREAS; g++) begin : gArea
      logic csQ;
      always_ff @(posedge clk) begin
        if (!rstN) csQ <= 1'b1;
        else       csQ <= !strobe.loadMrs;
      end
      assign sdCsN[g] = csQ;
    end
  endgenerate

  assign sdRasN = cmdQ.rasN;
  assign sdCasN = cmdQ.casN;
  assign sdWeN  = cmdQ.weN;
  assign sdAddr = addrQ;

  AST_MRS_ONE_CYCLE: assert property (@(posedge clk) disable iff (!rstN)
    !sdRasN |=> sdRasN); // R4
  AST_ALL_AREAS_SELECTED: assert property (@(posedge clk) disable iff (!rstN)
    (!sdRasN && !sdCasN && !sdWeN) |-> (sdCsN == '0)); // R4
  AST_CS_ONLY_WITH_CMD: assert property (@(posedge clk) disable iff (!rstN)
    (sdCsN != {NUM_AREAS{1'b1}}) |-> (!sdRasN && !sdCasN && !sdWeN)); // R4

endmodule

// File: rtl/sdram_modeset_gate.sv
module sdram_modeset_gate
  import modeset_pkg::*;
#(
  parameter int                ADDR_W    = 32,
  parameter int                DATA_W    = 32,
  parameter int                MODE_W    = 16,
  parameter int                NUM_AREAS = 2,
  parameter logic [ADDR_W-1:0] WIN_BASE  = 32'h0FF0_0000
) (
  input  logic                 clk,
  input  logic                 rstN,
  input  logic                 busIs16,
  input  logic                 cpuReq,
  input  logic                 cpuWr,
  input  logic [ADDR_W-1:0]    cpuAddr,
  input  logic [DATA_W-1:0]    cpuWdata,
  output logic                 cpuAck,
  output logic                 cpuErr,
  output logic                 fwdReq,
  output logic                 fwdWr,
  output logic [ADDR_W-1:0]    fwdAddr,
  output logic [DATA_W-1:0]    fwdWdata,
  input  logic                 fwdAck,
  output logic [NUM_AREAS-1:0] sdCsN,
  output logic                 sdRasN,
  output logic                 sdCasN,
  output logic                 sdWeN,
  output logic [MODE_W-1:0]    sdAddr
);

  ctlStrobe_t strobe;
  logic       inWin, ackWin, fwdEn;

  modeset_ctrl uCtrl (
    .clk    (clk),
    .rstN   (rstN),
    .cpuReq (cpuReq),
    .cpuWr  (cpuWr),
    .inWin  (inWin),
    .strobe (strobe),
    .ackWin (ackWin),
    .errOut (cpuErr),
    .fwdEn  (fwdEn)
  );

  modeset_dp #(
    .ADDR_W    (ADDR_W),
    .MODE_W    (MODE_W),
    .NUM_AREAS (NUM_AREAS),
    .WIN_BASE  (WIN_BASE)
  ) uDp (
    .clk     (clk),
    .rstN    (rstN),
    .cpuAddr (cpuAddr),
    .busIs16 (busIs16),
    .strobe  (strobe),
    .inWin   (inWin),
    .sdCsN   (sdCsN),
    .sdRasN  (sdRasN),
    .sdCasN  (sdCasN),
    .sdWeN   (sdWeN),
    .sdAddr  (sdAddr)
  );

  assign fwdReq   = fwdEn;
  assign fwdWr    = cpuWr;
  assign fwdAddr  = cpuAddr;
  assign fwdWdata = cpuWdata;
  assign cpuAck   = ackWin | (fwdEn & fwdAck);

  // shadow of "a command has been seen on the pins", for the checks below
  logic mrsOnPins, everIssued;
  assign mrsOnPins = !sdRasN && !sdCasN && !sdWeN;
  always_ff @(posedge clk) begin
    if (!rstN)          everIssued <= 1'b0;
    else if (mrsOnPins) everIssued <= 1'b1;
  end

  AST_NO_FWD_UNPROGRAMMED: assert property (@(posedge clk) disable iff (!rstN)
    fwdReq |-> everIssued); // R7
  AST_ACK_AFTER_CMD: assert property (@(posedge clk) disable iff (!rstN)
    mrsOnPins |=> cpuAck); // R6
  AST_ERR_NOT_FWD: assert property (@(posedge clk) disable iff (!rstN)
    cpuErr |-> !fwdReq); // R7

endmodule

// File: tb/sdram_modeset_gate_test.sv
module sdram_modeset_gate_test;

  localparam int ADDR_W = 16;
  localparam int DATA_W = 16;
  localparam int MODE_W = 6;
  localparam int NAREA  = 2;
  localparam logic [ADDR_W-1:0] BASE = 16'h1400;
  localparam int SPAN = 1 << (MODE_W + 2);

  logic clk = 1'b0;
  logic rstN = 1'b0;
  logic busIs16 = 1'b0;
  logic cpuReq = 1'b0;
  logic cpuWr = 1'b0;
  logic [ADDR_W-1:0] cpuAddr = '0;
  logic [DATA_W-1:0] cpuWdata = '0;
  logic fwdAck = 1'b0;
  logic cpuAck, cpuErr, fwdReq, fwdWr;
  logic [ADDR_W-1:0] fwdAddr;
  logic [DATA_W-1:0] fwdWdata;
  logic [NAREA-1:0] sdCsN;
  logic sdRasN, sdCasN, sdWeN;
  logic [MODE_W-1:0] sdAddr;

  int nChk = 0;
  int nBad = 0;
  bit finished = 1'b0;

  always #5 clk = ~clk;

  sdram_modeset_gate #(
    .ADDR_W(ADDR_W), .DATA_W(DATA_W), .MODE_W(MODE_W),
    .NUM_AREAS(NAREA), .WIN_BASE(BASE)
  ) uut (
    .clk(clk), .rstN(rstN), .busIs16(busIs16),
    .cpuReq(cpuReq), .cpuWr(cpuWr), .cpuAddr(cpuAddr), .cpuWdata(cpuWdata),
    .cpuAck(cpuAck), .cpuErr(cpuErr),
    .fwdReq(fwdReq), .fwdWr(fwdWr), .fwdAddr(fwdAddr), .fwdWdata(fwdWdata),
    .fwdAck(fwdAck),
    .sdCsN(sdCsN), .sdRasN(sdRasN), .sdCasN(sdCasN), .sdWeN(sdWeN),
    .sdAddr(sdAddr)
  );

  task automatic chk(input bit ok, input string req, input longint act, input longint exp);
    nChk++;
    if (!ok) begin
      nBad++;
      $display("FAIL %s: actual %0h expected %0h at %0t", req, act, exp, $time);
    end
  endtask

  // packed view of the pins: {cs, ras, cas, we}
  function automatic logic [NAREA+2:0] pins();
    return {sdCsN, sdRasN, sdCasN, sdWeN};
  endfunction
  localparam logic [NAREA+2:0] IDLE_PINS = '1;
  localparam logic [NAREA+2:0] MRS_PINS  = '0;

  // mode write through the window; checks the command and the acknowledge
  task automatic modeWrite(input logic [ADDR_W-1:0] a, input logic [DATA_W-1:0] d,
                           input logic [MODE_W-1:0] expVal, input string req);
    cpuReq = 1'b1; cpuWr = 1'b1; cpuAddr = a; cpuWdata = d;
    @(negedge clk);
    chk(pins() == MRS_PINS && sdAddr == expVal && !cpuAck, req,
        {pins(), sdAddr}, {MRS_PINS, expVal});
    @(negedge clk);
    chk(cpuAck && pins() == IDLE_PINS && sdAddr == '0, "R6/R4",
        {cpuAck, pins()}, {1'b1, IDLE_PINS});
    cpuReq = 1'b0;
    @(negedge clk);
    chk(!cpuAck && pins() == IDLE_PINS, "R6", cpuAck, 0);
  endtask

  // ordinary request while locked: must be refused
  task automatic lockedReq(input logic [ADDR_W-1:0] a, input logic w);
    cpuReq = 1'b1; cpuWr = w; cpuAddr = a; cpuWdata = 16'hBEEF;
    #1;
    chk(!fwdReq, "R7", fwdReq, 0);
    @(negedge clk);
    chk(cpuErr && !fwdReq && !cpuAck, "R7", {cpuErr, fwdReq, cpuAck}, 3'b100);
    cpuReq = 1'b0;
    @(negedge clk);
    chk(!cpuErr, "R7", cpuErr, 0);
  endtask

  // ordinary request once unlocked: passed through
  task automatic openReq(input logic [ADDR_W-1:0] a, input logic w, input logic [DATA_W-1:0] d);
    cpuReq = 1'b1; cpuWr = w; cpuAddr = a; cpuWdata = d;
    #1;
    chk(fwdReq && fwdWr == w && fwdAddr == a && fwdWdata == d && !cpuAck, "R8",
        {fwdReq, fwdWr, fwdAddr, fwdWdata}, {1'b1, w, a, d});
    @(negedge clk);
    chk(fwdReq && !cpuErr && !cpuAck, "R8", {fwdReq, cpuErr, cpuAck}, 3'b100);
    fwdAck = 1'b1;
    #1;
    chk(cpuAck, "R8", cpuAck, 1);
    @(negedge clk);
    fwdAck = 1'b0; cpuReq = 1'b0;
    #1;
    chk(!fwdReq && !cpuAck && pins() == IDLE_PINS, "R8", {fwdReq, cpuAck}, 0);
    @(negedge clk);
  endtask

  initial begin : watchdog
    repeat (200000) @(posedge clk);
    if (!finished) begin
      nChk++; nBad++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", nChk, nBad);
      $finish;
    end
  end

  initial begin : stim
    repeat (3) @(negedge clk);
    // R1: reset state
    chk(pins() == IDLE_PINS && sdAddr == '0, "R1", {pins(), sdAddr}, {IDLE_PINS, 6'd0});
    chk(!cpuAck && !cpuErr && !fwdReq, "R1", {cpuAck, cpuErr, fwdReq}, 0);
    rstN = 1'b1;
    @(negedge clk);
    chk(pins() == IDLE_PINS && !cpuAck && !cpuErr, "R1", pins(), IDLE_PINS);

    // R7: locked, below and above the window, write and read
    lockedReq(16'h0040, 1'b1);
    lockedReq(BASE - 16'd1, 1'b0);
    lockedReq(BASE + 16'(SPAN), 1'b1);

    // R9: read inside window acknowledged, no command, still locked
    cpuReq = 1'b1; cpuWr = 1'b0; cpuAddr = BASE + 16'h0024;
    @(negedge clk);
    chk(cpuAck && pins() == IDLE_PINS && !cpuErr, "R9", {cpuAck, pins()}, {1'b1, IDLE_PINS});
    cpuReq = 1'b0;
    @(negedge clk);
    chk(!cpuAck && pins() == IDLE_PINS, "R9", cpuAck, 0);
    lockedReq(16'h0100, 1'b1); // R9 read did not unlock

    // R2: every offset on a 32-bit bus
    busIs16 = 1'b0;
    for (int off = 0; off < SPAN; off++)
      modeWrite(BASE + 16'(off), 16'(off * 7 + 3), MODE_W'(off >> 2), "R2");

    // R3: every offset on a 16-bit bus, upper half aliases
    busIs16 = 1'b1;
    for (int off = 0; off < SPAN; off++)
      modeWrite(BASE + 16'(off), 16'(off * 13 + 1), MODE_W'(off >> 1), "R3");

    // R5: data bus ignored
    busIs16 = 1'b0;
    modeWrite(BASE + 16'h00B4, 16'h0000, 6'd45, "R5");
    modeWrite(BASE + 16'h00B4, 16'hFFFF, 6'd45, "R5");
    modeWrite(BASE + 16'h00B4, 16'hA5C3, 6'd45, "R5");

    // R8: pass-through after programming, edges around the window
    openReq(16'h0123, 1'b1, 16'h5A5A);
    openReq(BASE - 16'd1, 1'b0, 16'h0F0F);
    openReq(BASE + 16'(SPAN), 1'b1, 16'h1234);
    openReq(16'hFFFE, 1'b0, 16'h0000);

    // R9: reads inside the window still issue no command after unlocking
    cpuReq = 1'b1; cpuWr = 1'b0; cpuAddr = BASE;
    #1;
    chk(!fwdReq, "R9", fwdReq, 0);
    @(negedge clk);
    chk(cpuAck && pins() == IDLE_PINS, "R9", {cpuAck, pins()}, {1'b1, IDLE_PINS});
    cpuReq = 1'b0;
    @(negedge clk);

    finished = 1'b1;
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", nChk, nBad);
    $finish;
  end

endmodule